// File: doc/BRIEF.md
# Lock-Window Boost-Up Controller

This block speeds up PLL acquisition by driving an extra boost output into the loop filter while the loop is still far from lock. It watches the feedback divider's down-count value and builds a lock window around the divider's terminal count. It then judges each up or down correction pulse from the phase detector against that window. While boost is armed, every correction pulse is mirrored onto the boost output in its own direction. An up correction drives the output high and a down correction drives it low. At all other times the output is released (high impedance).

The first correction pulse whose every sampled cycle falls inside the window shows that the phase error is small. Boost then switches off and stays off until the operate input is taken low and raised again. Later changes to the divider ratio do not re-arm it. Taking the operate input low releases the output and clears all pulse tracking.

The block runs entirely in the divider's input-clock domain. The feedback divider counts down from ratio−1 to 0, and the terminal count is the cycle in which the count is 0.

Top module: `lbc_boost_ctrl`

## Requirements
- R1: The window is open in every cycle where fb_count ≤ H or fb_count ≥ fb_ratio − H + 1, with H = WIN_LEN/2 (31 by default). This gives the H cycles before the terminal count (0), the terminal count itself, and the H−1 cycles after it. For WIN_LEN = 62 that is 62 cycles per divider period.
- R2: While armed with opr high, db_en is 1 in any cycle where only corr_up is high, with db_lvl = 1. It is also 1 in any cycle where only corr_dn is high, with db_lvl = 0.
- R3: In any cycle where corr_up and corr_dn are both high or both low, db_en = 0 and db_lvl = 0, even while armed.
- R4: A pulse is a run of consecutive cycles with corr_up or corr_dn high. If the window is open in every cycle of a pulse, boost is disarmed from the cycle after the pulse ends. Later pulses then give db_en = 0.
- R5: A pulse whose first cycle lies before the window opens does not disarm boost.
- R6: A pulse that is still high in a cycle where the window has closed does not disarm boost.
- R7: Once disarmed, changing fb_ratio does not re-arm boost, and out-of-window pulses keep db_en = 0.
- R8: After reset boost is disarmed and db_en = 0. A rising edge of opr, sampled on clk, arms boost from the next cycle.
- R9: While opr is low, db_en = 0 and pulses are ignored. A low opr also disarms boost and clears pulse tracking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divider input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opr | input | 1 | Operate enable; rising edge arms boost |
| fb_count | input | CNT_W | Feedback divider down-count value |
| fb_ratio | input | CNT_W | Feedback divider ratio currently loaded |
| corr_up | input | 1 | Up correction pulse from phase detector |
| corr_dn | input | 1 | Down correction pulse from phase detector |
| db_en | output | 1 | Boost drive enable (0 = released) |
| db_lvl | output | 1 | Boost drive level when enabled |

## Verification
The bench builds the block with CNT_W = 10 and the default 62-cycle window. It runs divider ratios of 100 and 80, so a full divider period passes within 100 cycles. Both window edges, and the wrap from 0 to ratio−1, are therefore reached many times in a short run. Single-cycle pulses placed one count outside and exactly on each window edge pin down the window bounds. The ratio switch moves the closing edge, which shows that the window follows fb_ratio.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

  typedef enum logic [1:0] {
    DRV_OFF = 2'd0,
    DRV_UP  = 2'd1,
    DRV_DN  = 2'd2
  } drive_e;

  // Window test on a down counter: near zero (before/at terminal) or just
  // after the reload to ratio-1. Written without subtraction.
  function automatic logic win_open_f(input int unsigned cnt,
                                      input int unsigned ratio,
                                      input int unsigned half);
    return (cnt <= half) || ((cnt + half) >= (ratio + 1));
  endfunction

  // Only one active direction requests a drive.
  function automatic drive_e drive_sel_f(input logic up, input logic dn);
    if (up && !dn) return DRV_UP;
    if (dn && !up) return DRV_DN;
    return DRV_OFF;
  endfunction

endpackage

// File: rtl/lbc_window.sv
module lbc_window #(
  parameter int CNT_W   = 18,
  parameter int WIN_LEN = 62
) (
  input  logic [CNT_W-1:0] fb_count,
  input  logic [CNT_W-1:0] fb_ratio,
  output logic             win_open
);
  localparam int HALF = WIN_LEN / 2;

  assign win_open = lbc_pkg::win_open_f(32'(fb_count), 32'(fb_ratio), HALF);
endmodule

// File: rtl/lbc_pulse_judge.sv
module lbc_pulse_judge (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic corr_up,
  input  logic corr_dn,
  input  logic win_open,
  output logic hit
);
  logic active;
  logic act_q;
  logic ok_q;

  assign active = corr_up | corr_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ok_q  <= 1'b0;
    end else if (!enable) begin
      act_q <= 1'b0;
      ok_q  <= 1'b0;
    end else begin
      act_q <= active;
      if (active) ok_q <= act_q ? (ok_q & win_open) : win_open;
    end
  end

  // Pulse just ended and every cycle of it lay inside the window.
  assign hit = enable & act_q & ~active & ok_q;
endmodule

// File: rtl/lbc_arm.sv
module lbc_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic opr,
  input  logic hit,
  output logic armed,
  output logic opr_rise
);
  logic opr_q;

  assign opr_rise = opr & ~opr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opr_q <= 1'b0;
      armed <= 1'b0;
    end else begin
      opr_q <= opr;
      if (!opr)          armed <= 1'b0;
      else if (opr_rise) armed <= 1'b1;
      else if (hit)      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/lbc_boost_ctrl.sv
module lbc_boost_ctrl #(
  parameter int CNT_W   = 18,
  parameter int WIN_LEN = 62
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opr,
  input  logic [CNT_W-1:0] fb_count,
  input  logic [CNT_W-1:0] fb_ratio,
  input  logic             corr_up,
  input  logic             corr_dn,
  output logic             db_en,
  output logic             db_lvl
);
  import lbc_pkg::*;

  logic   win_open;
  logic   hit;
  logic   armed;
  logic   opr_rise;
  drive_e drv;

  lbc_window #(.CNT_W(CNT_W), .WIN_LEN(WIN_LEN)) u_win (
    .fb_count (fb_count),
    .fb_ratio (fb_ratio),
    .win_open (win_open)
  );

  lbc_pulse_judge u_judge (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (opr),
    .corr_up  (corr_up),
    .corr_dn  (corr_dn),
    .win_open (win_open),
    .hit      (hit)
  );

  lbc_arm u_arm (
    .clk      (clk),
    .rst_n    (rst_n),
    .opr      (opr),
    .hit      (hit),
    .armed    (armed),
    .opr_rise (opr_rise)
  );

  assign drv    = drive_sel_f(corr_up, corr_dn);
  assign db_en  = armed & opr & (drv != DRV_OFF);
  assign db_lvl = db_en & (drv == DRV_UP);
endmodule

// File: rtl/lbc_boost_chk.sv
module lbc_boost_chk (
  input logic clk,
  input logic rst_n,
  input logic opr,
  input logic corr_up,
  input logic corr_dn,
  input logic db_en,
  input logic db_lvl,
  input logic armed,
  input logic hit,
  input logic opr_rise
);
  p_released_opr_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !opr |-> !db_en);

  p_no_drive_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_up == corr_dn) |-> (!db_en && !db_lvl));

  p_level_direction_r2: assert property (@(posedge clk) disable iff (!rst_n)
    db_en |-> (db_lvl == corr_up) && (corr_up != corr_dn));

  p_disarm_after_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !opr_rise) |=> !armed);

  p_arm_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    opr_rise |=> armed);

  p_stays_disarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !opr_rise) |=> !armed);
endmodule

bind lbc_boost_ctrl lbc_boost_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .opr      (opr),
  .corr_up  (corr_up),
  .corr_dn  (corr_dn),
  .db_en    (db_en),
  .db_lvl   (db_lvl),
  .armed    (armed),
  .hit      (hit),
  .opr_rise (opr_rise)
);

// File: tb/tb_lbc_boost_ctrl.sv
module tb_lbc_boost_ctrl;
  localparam int CNT_W   = 10;
  localparam int WIN_LEN = 62;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             opr;
  logic [CNT_W-1:0] fb_count;
  logic [CNT_W-1:0] fb_ratio;
  logic             corr_up;
  logic             corr_dn;
  logic             db_en;
  logic             db_lvl;

  typedef struct {
    string req;
    logic  en;
    logic  lvl;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  always #5 clk = ~clk;

  lbc_boost_ctrl #(.CNT_W(CNT_W), .WIN_LEN(WIN_LEN)) dut (
    .clk(clk), .rst_n(rst_n), .opr(opr), .fb_count(fb_count),
    .fb_ratio(fb_ratio), .corr_up(corr_up), .corr_dn(corr_dn),
    .db_en(db_en), .db_lvl(db_lvl)
  );

  // Monitor: compare queued expectations away from the active edge.
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_checks++;
      if (db_en !== e.en || db_lvl !== e.lvl) begin
        n_fail++;
        $display("FAIL %s: en/lvl actual %b/%b expected %b/%b (count %0d)",
                 e.req, db_en, db_lvl, e.en, e.lvl, fb_count);
      end
    end
  end

  task automatic expect_out(input string req, input logic en, input logic lvl);
    exp_t e;
    e.req = req; e.en = en; e.lvl = lvl;
    q.push_back(e);
  endtask

  // One divider cycle: the bench's own down counter reloads ratio-1 after 0.
  task automatic step();
    @(posedge clk); #1;
    fb_count = (fb_count == '0) ? fb_ratio - 1'b1 : fb_count - 1'b1;
  endtask

  task automatic goto_count(input int v);
    do step(); while (int'(fb_count) != v);
  endtask

  task automatic pulse(input logic u, input logic d, input int start,
                       input int len, input logic en, input logic lvl,
                       input string req);
    goto_count(start);
    corr_up = u; corr_dn = d;
    expect_out(req, en, lvl);
    for (int i = 1; i < len; i++) begin
      step();
      expect_out(req, en, lvl);
    end
    step();
    corr_up = 1'b0; corr_dn = 1'b0;
    expect_out(req, 1'b0, 1'b0);
  endtask

  task automatic rearm();
    step(); opr = 1'b0;
    step(); step();
    opr = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; opr = 1'b0; fb_ratio = 10'd100; fb_count = 10'd99;
    corr_up = 1'b0; corr_dn = 1'b0;
    repeat (3) step();
    expect_out("R8 reset state", 1'b0, 1'b0);
    step(); rst_n = 1'b1;

    // R9: opr low ignores pulses
    pulse(1'b1, 1'b0, 50, 3, 1'b0, 1'b0, "R9 opr low");

    step(); opr = 1'b1;
    // R2: direction mirrored (count 50 outside window for ratio 100)
    pulse(1'b1, 1'b0, 50, 3, 1'b1, 1'b1, "R2 up drive");
    pulse(1'b0, 1'b1, 50, 3, 1'b1, 1'b0, "R2 down drive");
    // R3: both active, and idle
    pulse(1'b1, 1'b1, 50, 2, 1'b0, 1'b0, "R3 both active");
    step(); expect_out("R3 idle armed", 1'b0, 1'b0);

    // R5: starts at 33, runs into window (33..29)
    pulse(1'b1, 1'b0, 33, 5, 1'b1, 1'b1, "R5 early start");
    pulse(1'b1, 1'b0, 50, 2, 1'b1, 1'b1, "R5 still armed");
    // R6: 72,71,70 inside, 69 after close
    pulse(1'b1, 1'b0, 72, 4, 1'b1, 1'b1, "R6 late end");
    pulse(1'b1, 1'b0, 50, 2, 1'b1, 1'b1, "R6 still armed");

    // R1 edges: 32 and 69 are just outside
    pulse(1'b1, 1'b0, 32, 1, 1'b1, 1'b1, "R1 count 32");
    pulse(1'b1, 1'b0, 50, 1, 1'b1, 1'b1, "R1 after 32 armed");
    pulse(1'b1, 1'b0, 69, 1, 1'b1, 1'b1, "R1 count 69");
    pulse(1'b1, 1'b0, 50, 1, 1'b1, 1'b1, "R1 after 69 armed");
    // R1/R4: 31 is the first open cycle
    pulse(1'b1, 1'b0, 31, 1, 1'b1, 1'b1, "R4 hit at 31");
    pulse(1'b1, 1'b0, 50, 2, 1'b0, 1'b0, "R4 disarmed");
    pulse(1'b0, 1'b1, 90, 2, 1'b0, 1'b0, "R4 disarmed down");

    // R1 closing edge: 70 is the last open cycle
    rearm();
    pulse(1'b0, 1'b1, 70, 1, 1'b1, 1'b0, "R1 hit at 70");
    pulse(1'b1, 1'b0, 50, 1, 1'b0, 1'b0, "R1 disarmed after 70");

    // R7: new ratio does not re-arm
    goto_count(40);
    fb_ratio = 10'd80;
    pulse(1'b1, 1'b0, 40, 2, 1'b0, 1'b0, "R7 ratio change");
    pulse(1'b0, 1'b1, 35, 2, 1'b0, 1'b0, "R7 ratio change down");

    // R8: opr re-arms; ratio 80 opens window at count >= 50
    rearm();
    pulse(1'b1, 1'b0, 40, 2, 1'b1, 1'b1, "R8 re-armed");
    pulse(1'b1, 1'b0, 49, 1, 1'b1, 1'b1, "R1 ratio 80 count 49");
    pulse(1'b1, 1'b0, 50, 1, 1'b1, 1'b1, "R1 ratio 80 hit at 50");
    pulse(1'b1, 1'b0, 40, 1, 1'b0, 1'b0, "R4 disarmed ratio 80");

    // R4: long down pulse fully inside (20..11)
    rearm();
    pulse(1'b0, 1'b1, 20, 10, 1'b1, 1'b0, "R4 long inside");
    pulse(1'b0, 1'b1, 40, 2, 1'b0, 1'b0, "R4 after long");

    // R9: opr drop releases output mid-arm
    rearm();
    goto_count(40);
    corr_up = 1'b1; expect_out("R9 armed drive", 1'b1, 1'b1);
    step(); opr = 1'b0; expect_out("R9 opr dropped", 1'b0, 1'b0);
    step(); corr_up = 1'b0;
    step(); step();

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule